// File: doc/BRIEF.md
# Auxiliary Interrupt Status Register

This block keeps a 32-bit secondary interrupt status word for a network controller. Five single-cycle event pulses arrive from the transmit path, the receive path, the link monitor and the flow-control logic. Each pulse is captured into its own sticky status bit. Three of the sources are first gated by enable bits that come from a companion control register.

Software clears a status bit by writing a 1 to its position through a plain write strobe and data bus. Writing 0 leaves the bit alone. A summary bit reflects whether any captured source is still pending. This summary is combined with a global enable to produce the interrupt request line.

Top module: `aux_irq_status`

## Requirements
- R1: After reset, `status` reads 0x00000000 and `summary` and `irq` are 0.
- R2: Bit 31 (transmit early) sets on the clock edge that samples `ev_tx_moved` high while `en_tx_early` is 1. With `en_tx_early` at 0 the pulse leaves bit 31 unchanged.
- R3: Bit 30 (receive early) sets on the clock edge that samples `ev_rx_first_desc` high while `en_rx_early` is 1. With `en_rx_early` at 0 the pulse leaves bit 30 unchanged.
- R4: Bit 29 sets on any `ev_link_change` pulse and bit 28 sets on any `ev_tx_deferred` pulse. Neither of these is gated.
- R5: Bit 26 sets on an `ev_pause_rx` pulse only while `en_pause` is 1.
- R6: A cycle with `wr_en` high clears every status bit whose `wr_data` bit is 1. Bits whose `wr_data` bit is 0 keep their value.
- R7: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up 1.
- R8: Bit 16 (`summary`) is 1 exactly when any of bits 31, 30, 29, 28 or 26 is 1. It is not stored and cannot be written.
- R9: Bits 27, 25 to 17 and 15 to 0 always read 0, whatever is written to them.
- R10: `irq` is 1 exactly when `summary` is 1 and `irq_global_en` is 1. The path from `irq_global_en` to `irq` has no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_tx_moved | input | 1 | Pulse: transmit packet fully moved into the TX FIFO |
| ev_rx_first_desc | input | 1 | Pulse: received packet filled its first descriptor |
| ev_link_change | input | 1 | Pulse: link status changed |
| ev_tx_deferred | input | 1 | Pulse: transmission deferred |
| ev_pause_rx | input | 1 | Pulse: pause frame received |
| en_tx_early | input | 1 | Enable for bit 31 |
| en_rx_early | input | 1 | Enable for bit 30 |
| en_pause | input | 1 | Enable for bit 26 |
| wr_en | input | 1 | Write strobe for write-one-to-clear |
| wr_data | input | 32 | Write data; a 1 clears the matching bit |
| irq_global_en | input | 1 | Global interrupt enable |
| status | output | 32 | Status word as read by software |
| summary | output | 1 | Any pending source (same as bit 16) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a collision between a clear and a set. A bit that is already set must be hit by a write-one-to-clear and a fresh event on the same clock edge. With a correct design the bit stays 1, and the test can only tell this apart from "clear wins" because the bit was 1 beforehand. The stimulus therefore sets the link-change bit first. On one negative edge it then raises both the write strobe and the event, and samples the bit after the next rising edge. The same approach is used with enables held low: the bit is first brought to a known 0, so that a gated pulse that wrongly slips through is visible.

// File: rtl/aux_irq_status.sv
module aux_irq_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_tx_moved,
  input  logic         ev_rx_first_desc,
  input  logic         ev_link_change,
  input  logic         ev_tx_deferred,
  input  logic         ev_pause_rx,
  input  logic         en_tx_early,
  input  logic         en_rx_early,
  input  logic         en_pause,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         irq_global_en,
  output logic [W-1:0] status,
  output logic         summary,
  output logic         irq
);
  localparam int B_TXE = 31;
  localparam int B_RXE = 30;
  localparam int B_LNK = 29;
  localparam int B_DEF = 28;
  localparam int B_PAU = 26;
  localparam int B_SUM = 16;
  localparam int NSRC  = 5;

  logic [NSRC-1:0] hit, wipe, pend_q;
  logic            unused_wr;

  assign hit = {ev_tx_moved & en_tx_early,
                ev_rx_first_desc & en_rx_early,
                ev_link_change,
                ev_tx_deferred,
                ev_pause_rx & en_pause};

  assign wipe = wr_en ? {wr_data[B_TXE], wr_data[B_RXE], wr_data[B_LNK],
                         wr_data[B_DEF], wr_data[B_PAU]} : '0;

  assign unused_wr = ^{wr_data[W-1:B_TXE+1], wr_data[27], wr_data[25:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= hit | (pend_q & ~wipe);

  assign summary = |pend_q;
  assign irq     = summary & irq_global_en;

  always_comb begin
    status        = '0;
    status[B_TXE] = pend_q[4];
    status[B_RXE] = pend_q[3];
    status[B_LNK] = pend_q[2];
    status[B_DEF] = pend_q[1];
    status[B_PAU] = pend_q[0];
    status[B_SUM] = summary;
  end
endmodule

module aux_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_tx_moved,
  input logic        ev_rx_first_desc,
  input logic        ev_link_change,
  input logic        ev_tx_deferred,
  input logic        ev_pause_rx,
  input logic        en_tx_early,
  input logic        en_rx_early,
  input logic        en_pause,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        irq_global_en,
  input logic [31:0] status,
  input logic        summary,
  input logic        irq
);
  assert_tx_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[31]) |-> $past(ev_tx_moved && en_tx_early));
  assert_rx_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[30]) |-> $past(ev_rx_first_desc && en_rx_early));
  assert_link_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_change |=> status[29]);
  assert_pause_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[26]) |-> $past(ev_pause_rx && en_pause));
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[28] && !ev_tx_deferred) |=> !status[28]);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[29] && !(wr_en && wr_data[29])) |=> status[29]);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_deferred && wr_en && wr_data[28]) |=> status[28]);
  assert_summary_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(summary) |-> $past(ev_tx_moved || ev_rx_first_desc || ev_link_change
                             || ev_tx_deferred || ev_pause_rx));
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 32'h0BFE_FFFF) == 32'h0);
  assert_irq_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_global_en && status[16]));
endmodule

bind aux_irq_status aux_irq_status_chk u_chk (.*);

// File: tb/aux_irq_status_bench.sv
`timescale 1ns/1ps
module aux_irq_status_bench;
  logic clk = 0, rst_n = 0;
  logic ev_tx_moved = 0, ev_rx_first_desc = 0, ev_link_change = 0;
  logic ev_tx_deferred = 0, ev_pause_rx = 0;
  logic en_tx_early = 0, en_rx_early = 0, en_pause = 0;
  logic wr_en = 0, irq_global_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] status;
  logic summary, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aux_irq_status u_aux_irq_status (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive for one cycle on a negedge, release on the next; sample then
  task automatic cycle(input logic tx, rx, lk, df, pa, we, input logic [31:0] wd);
    @(negedge clk);
    ev_tx_moved = tx; ev_rx_first_desc = rx; ev_link_change = lk;
    ev_tx_deferred = df; ev_pause_rx = pa; wr_en = we; wr_data = wd;
    @(negedge clk);
    {ev_tx_moved, ev_rx_first_desc, ev_link_change, ev_tx_deferred, ev_pause_rx, wr_en} = '0;
    wr_data = '0;
  endtask

  task automatic clear_all();
    cycle(0,0,0,0,0,1,32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    check("R1 status", status, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 summary", {31'h0, summary}, 32'h0);
  endtask

  task automatic t_tx_early();
    en_tx_early = 0;
    cycle(1,0,0,0,0,0,0);
    check("R2 gated off", status, 32'h0);
    en_tx_early = 1;
    cycle(1,0,0,0,0,0,0);
    check("R2 set", status, 32'h8001_0000);
    check("R8 summary", {31'h0, summary}, 32'h1);
    irq_global_en = 0; #1;
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    irq_global_en = 1; #1;
    check("R10 irq", {31'h0, irq}, 32'h1);
    cycle(0,0,0,0,0,1,32'h8000_0000);
    check("R6 clear 31", status, 32'h0);
    check("R10 irq drops", {31'h0, irq}, 32'h0);
    en_tx_early = 0; irq_global_en = 0;
  endtask

  task automatic t_rx_early();
    cycle(0,1,0,0,0,0,0);
    check("R3 gated off", status, 32'h0);
    en_rx_early = 1;
    cycle(0,1,0,0,0,0,0);
    check("R3 set", status, 32'h4001_0000);
    en_rx_early = 0;
    clear_all();
  endtask

  task automatic t_link_def();
    cycle(0,0,1,0,0,0,0);
    check("R4 link", status, 32'h2001_0000);
    cycle(0,0,0,1,0,0,0);
    check("R4 deferred", status, 32'h3001_0000);
    clear_all();
    check("R6 clear all", status, 32'h0);
  endtask

  task automatic t_pause();
    cycle(0,0,0,0,1,0,0);
    check("R5 gated off", status, 32'h0);
    en_pause = 1;
    cycle(0,0,0,0,1,0,0);
    check("R5 set", status, 32'h0401_0000);
    en_pause = 0;
    clear_all();
  endtask

  task automatic t_w1c_masks();
    en_tx_early = 1; en_rx_early = 1; en_pause = 1;
    cycle(1,1,1,1,1,0,0);
    check("R8 all set", status, 32'hF401_0000);
    cycle(0,0,0,0,0,1,32'h0);
    check("R6 write zero", status, 32'hF401_0000);
    cycle(0,0,0,0,0,1,32'h0BFF_FFFF);
    check("R8 R9 write sum/reserved", status, 32'hF401_0000);
    cycle(0,0,0,0,0,1,32'h5000_0000);
    check("R6 partial clear", status, 32'hA401_0000);
    clear_all();
    check("R8 summary clears", status, 32'h0);
    en_tx_early = 0; en_rx_early = 0; en_pause = 0;
  endtask

  task automatic t_set_wins();
    cycle(0,0,1,0,0,0,0);
    cycle(0,0,1,0,0,1,32'h2000_0000);
    check("R7 set wins", status, 32'h2001_0000);
    clear_all();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx_early();
        t_rx_early();
        t_link_def();
        t_pause();
        t_w1c_masks();
        t_set_wins();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog got=hung exp=done");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule